// File: doc/BRIEF.md
# Direct-Mapped Write-Through Block Cache

This block places a single-way cache between a processor load/store port and a memory port that moves a whole 128-bit block per transfer. It holds 4096 lines. Each line carries a valid flag, a 16-bit tag and four 32-bit words. Any memory block can sit in only one line, and that line is chosen by the low bits of the block address. A read that hits is answered combinationally, in the cycle the request is presented. A read that misses stalls the processor while the whole block is fetched and installed.

Every store goes to memory. On a store hit, the addressed word is patched into the line and the updated block is written out. On a store miss, the block is fetched first. The store word is spliced into the fetched data, the merged block is installed, and the same merged block is then written back. Words in the block that the store did not touch therefore keep their memory values.

The processor sees a single busy flag and a response strobe. Memory sees a request held until a ready pulse.

Top module: `wt_dm_cache`

## Requirements
- R1: The byte address splits into a word select in bits [3:2], a line index in bits [15:4] and a tag in bits [31:16]. Bits [1:0] have no effect on lookup or on the returned word.
- R2: An access hits only when the indexed line is valid and its stored tag equals the address tag. Two blocks with the same index and different tags evict each other.
- R3: After reset, every line is invalid. `cpuBusy`, `memReq` and `rspValid` are low, and the first access to any line misses.
- R4: A read hit raises `rspValid` with the requested word on `cpuRdata` in the same cycle the request is presented while idle. It issues no memory transfer.
- R5: A read miss issues one memory read (`memWe`=0) at the block-aligned address, with bits [3:0] zero. It installs the returned block, then raises `rspValid` with the requested word taken from that block.
- R6: A write hit replaces the addressed word in the line. It issues exactly one memory write (`memWe`=1) carrying the updated block, then acknowledges with `rspValid`.
- R7: A write miss performs one memory read of the block, then one memory write. The written block equals the fetched block with only the addressed word replaced, and the same merged block is installed in the cache.
- R8: `cpuBusy` is high from the cycle after a miss or write is accepted through the cycle in which `rspValid` is raised for it. Requests presented while `cpuBusy` is high are ignored.
- R9: `memReq` stays high, with `memAddr`, `memWe` and `memWdata` unchanged, until the clock edge at which `memReady` is sampled high, and that edge completes the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request, accepted when `cpuBusy` is low |
| cpuWe | input | 1 | 1 = store, 0 = load |
| cpuAddr | input | 32 | Byte address of the access |
| cpuWdata | input | 32 | Store data |
| cpuRdata | output | 32 | Load data, valid with `rspValid` on reads |
| cpuBusy | output | 1 | Cache is handling an earlier access |
| rspValid | output | 1 | Access completed this cycle |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | 1 = block write, 0 = block read |
| memAddr | output | 32 | Block-aligned memory address |
| memWdata | output | 128 | Block written to memory |
| memRdata | input | 128 | Block returned by memory, valid with `memReady` on reads |
| memReady | input | 1 | Memory completes the transfer at this edge |

## Verification
On a write miss, the installation of the fetched block and the merge of the store word happen at the same clock edge. The store word has to land in exactly one word position while the fetched data fills the other three. This is provoked by stores to lines that were never loaded, and to lines that were just evicted by a conflicting tag. The result is judged two ways. First, the block the memory model captures must equal its previous contents with only the addressed word replaced. Second, follow-up loads to the stored word and to its neighbours must hit and return the merged values. A second collision is checked by keeping a store request asserted at a different index while a read miss is in flight. No extra memory write may appear, and that block must later read back unchanged.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } wtcState_e;

  // Strobes from the controller into the datapath
  typedef struct packed {
    logic latchReq;    // capture the incoming processor request
    logic useLatched;  // look up with the captured address
    logic storeWord;   // patch one word into a hitting line
    logic fillLine;    // install the (merged) fetched block
  } wtcStrobe_t;

endpackage

// File: rtl/wtc_datapath.sv
module wtc_datapath
  import wtc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int INDEX_W = 12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  wtcStrobe_t                strobe,
  input  logic                      cpuWe,
  input  logic [ADDR_W-1:0]         cpuAddr,
  input  logic [WORD_W-1:0]         cpuWdata,
  input  logic [WORD_W*WORDS-1:0]   memRdata,
  output logic                      hit,
  output logic [WORD_W-1:0]         cpuRdata,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [WORD_W*WORDS-1:0]   memWdata
);

  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = $clog2(WORDS);
  localparam int LOW_W  = BYTE_W + OFF_W;
  localparam int TAG_W  = ADDR_W - INDEX_W - LOW_W;
  localparam int LINE_W = WORD_W * WORDS;
  localparam int LINES  = 1 << INDEX_W;

  logic [LINE_W-1:0] dataArr [LINES];
  logic [TAG_W-1:0]  tagArr  [LINES];
  logic [LINES-1:0]  validVec;

  // Captured request (byte offset dropped)
  logic [ADDR_W-1:BYTE_W] latAddr;
  logic                   latWe;
  logic [WORD_W-1:0]      latWdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latAddr  <= '0;
      latWe    <= 1'b0;
      latWdata <= '0;
    end else if (strobe.latchReq) begin
      latAddr  <= cpuAddr[ADDR_W-1:BYTE_W];
      latWe    <= cpuWe;
      latWdata <= cpuWdata;
    end
  end

  logic [ADDR_W-1:BYTE_W] lookAddr;
  logic [INDEX_W-1:0]     lookIdx;
  logic [TAG_W-1:0]       lookTag;
  logic [OFF_W-1:0]       lookWord;
  logic [INDEX_W-1:0]     latIdx;
  logic [TAG_W-1:0]       latTag;
  logic [OFF_W-1:0]       latWord;
  logic [LINE_W-1:0]      lineRd;
  logic [LINE_W-1:0]      patchedLine;
  logic [LINE_W-1:0]      mergedBlock;
  logic [WORD_W-1:0]      lineWords [WORDS];

  assign lookAddr = strobe.useLatched ? latAddr : cpuAddr[ADDR_W-1:BYTE_W];
  assign lookWord = lookAddr[BYTE_W +: OFF_W];
  assign lookIdx  = lookAddr[LOW_W +: INDEX_W];
  assign lookTag  = lookAddr[ADDR_W-1 -: TAG_W];
  assign latWord  = latAddr[BYTE_W +: OFF_W];
  assign latIdx   = latAddr[LOW_W +: INDEX_W];
  assign latTag   = latAddr[ADDR_W-1 -: TAG_W];

  assign lineRd = dataArr[lookIdx];
  assign hit    = validVec[lookIdx] && (tagArr[lookIdx] == lookTag);

  // Word slicing, store patch on hit, and store merge on a fetched block
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign lineWords[w] = lineRd[w*WORD_W +: WORD_W];
    assign patchedLine[w*WORD_W +: WORD_W] =
      (lookWord == OFF_W'(w)) ? cpuWdata : lineRd[w*WORD_W +: WORD_W];
    assign mergedBlock[w*WORD_W +: WORD_W] =
      (latWe && latWord == OFF_W'(w)) ? latWdata : memRdata[w*WORD_W +: WORD_W];
  end

  assign cpuRdata = lineWords[lookWord];
  assign memAddr  = {latAddr[ADDR_W-1:LOW_W], {LOW_W{1'b0}}};
  assign memWdata = lineRd;

  always_ff @(posedge clk) begin
    if (strobe.fillLine) begin
      dataArr[latIdx] <= mergedBlock;
      tagArr[latIdx]  <= latTag;
    end else if (strobe.storeWord) begin
      dataArr[lookIdx] <= patchedLine;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                validVec         <= '0;
    else if (strobe.fillLine) validVec[latIdx] <= 1'b1;
  end

endmodule

// File: rtl/wtc_control.sv
module wtc_control
  import wtc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWe,
  input  logic       hit,
  input  logic       memReady,
  output wtcStrobe_t strobe,
  output logic       cpuBusy,
  output logic       rspValid,
  output logic       memReq,
  output logic       memWe
);

  wtcState_e state, nextState;
  logic      opWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opWe  <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.latchReq) opWe <= cpuWe;
    end
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    rspValid  = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (cpuReq) begin
          strobe.latchReq = 1'b1;
          if (!cpuWe && hit) begin
            rspValid = 1'b1;
          end else if (cpuWe && hit) begin
            strobe.storeWord = 1'b1;
            nextState        = ST_WRITE;
          end else begin
            nextState = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        strobe.useLatched = 1'b1;
        memReq            = 1'b1;
        if (memReady) begin
          strobe.fillLine = 1'b1;
          nextState       = opWe ? ST_WRITE : ST_DONE;
        end
      end
      ST_WRITE: begin
        strobe.useLatched = 1'b1;
        memReq            = 1'b1;
        memWe             = 1'b1;
        if (memReady) nextState = ST_DONE;
      end
      ST_DONE: begin
        strobe.useLatched = 1'b1;
        rspValid          = 1'b1;
        nextState         = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign cpuBusy = (state != ST_IDLE);

endmodule

// File: rtl/wt_dm_cache.sv
module wt_dm_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int INDEX_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cpuReq,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [WORD_W-1:0]       cpuWdata,
  output logic [WORD_W-1:0]       cpuRdata,
  output logic                    cpuBusy,
  output logic                    rspValid,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [WORD_W*WORDS-1:0] memWdata,
  input  logic [WORD_W*WORDS-1:0] memRdata,
  input  logic                    memReady
);

  wtcStrobe_t strobe;
  logic       hit;

  wtc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cpuReq   (cpuReq),
    .cpuWe    (cpuWe),
    .hit      (hit),
    .memReady (memReady),
    .strobe   (strobe),
    .cpuBusy  (cpuBusy),
    .rspValid (rspValid),
    .memReq   (memReq),
    .memWe    (memWe)
  );

  wtc_datapath #(
    .ADDR_W  (ADDR_W),
    .WORD_W  (WORD_W),
    .WORDS   (WORDS),
    .INDEX_W (INDEX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .memRdata (memRdata),
    .hit      (hit),
    .cpuRdata (cpuRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata)
  );

endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 128,
  parameter int LOW_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReq,
  input logic              cpuWe,
  input logic              cpuBusy,
  input logic              rspValid,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [LINE_W-1:0] memWdata,
  input logic              memReady
);

  // R9
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq);

  // R9
  mem_fields_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R5
  mem_addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[LOW_W-1:0] == '0);

  // R4
  idle_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuBusy |-> !memReq);

  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuBusy && rspValid |=> !cpuBusy);

  // R6
  store_goes_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuReq && cpuWe && !cpuBusy |=> cpuBusy && memReq);

  // R6
  write_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memReady |=> rspValid);

endmodule

bind wt_dm_cache wtc_checker #(
  .ADDR_W (ADDR_W),
  .LINE_W (WORD_W*WORDS),
  .LOW_W  ($clog2(WORD_W/8) + $clog2(WORDS))
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cpuReq   (cpuReq),
  .cpuWe    (cpuWe),
  .cpuBusy  (cpuBusy),
  .rspValid (rspValid),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .memWdata (memWdata),
  .memReady (memReady)
);

// File: tb/wt_dm_cache_tb.sv
`timescale 1ns/100ps
module wt_dm_cache_tb;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cpuReq = 1'b0, cpuWe = 1'b0;
  logic [31:0]  cpuAddr = '0, cpuWdata = '0;
  logic [31:0]  cpuRdata;
  logic         cpuBusy, rspValid, memReq, memWe;
  logic [31:0]  memAddr;
  logic [127:0] memWdata;
  logic [127:0] memRdata = '0;
  logic         memReady = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  wt_dm_cache u_dut (
    .clk(clk), .rstN(rstN), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .cpuBusy(cpuBusy), .rspValid(rspValid),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady)
  );

  // ---------------- memory model ----------------
  logic [127:0] memStore [logic [27:0]];
  int           memReads = 0, memWrites = 0, latCnt = 0;
  logic [31:0]  lastMemAddr = '0;

  function automatic logic [127:0] initBlock(input logic [27:0] b);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) r[i*32 +: 32] = {b, 2'(i), 2'b00} ^ 32'hC3A5_0000;
    return r;
  endfunction

  function automatic logic [127:0] refBlock(input logic [27:0] b);
    if (memStore.exists(b)) return memStore[b];
    return initBlock(b);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      memReady <= 1'b0;
      latCnt   <= 0;
    end else if (memReady) begin
      memReady <= 1'b0;
      latCnt   <= 0;
      if (memReq) begin
        lastMemAddr <= memAddr;
        if (memWe) begin
          memStore[memAddr[31:4]] = memWdata;
          memWrites <= memWrites + 1;
        end else begin
          memReads <= memReads + 1;
        end
      end
    end else if (memReq) begin
      if (latCnt == 2) begin
        memReady <= 1'b1;
        if (!memWe) memRdata <= refBlock(memAddr[31:4]);
      end else begin
        latCnt <= latCnt + 1;
      end
    end
  end

  // ---------------- checking ----------------
  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic doAccess(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          input logic expHit, input logic intrude, input string lbl);
    logic [127:0] preBlk, expBlk;
    logic [31:0]  got, expWord;
    logic         sawHit;
    int           rd0, wr0, waitC, w;
    w       = int'(addr[3:2]);
    preBlk  = refBlock(addr[31:4]);
    expWord = preBlk[w*32 +: 32];
    rd0 = memReads;
    wr0 = memWrites;
    @(negedge clk);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wd;
    #1;
    sawHit = rspValid && !cpuBusy;
    got    = cpuRdata;
    if (!sawHit) begin
      @(negedge clk);
      if (intrude) begin
        cpuReq = 1'b1; cpuWe = 1'b1; cpuAddr = addr ^ 32'h0000_0100; cpuWdata = 32'hBAD0_BAD0;
      end else begin
        cpuReq = 1'b0;
      end
      #1;
      waitC = 0;
      while (!rspValid && waitC < 64) begin
        @(negedge clk); #1; waitC++;
      end
      check(rspValid && cpuBusy, "R8 completion seen while busy", {rspValid, cpuBusy}, 2'b11);
      got    = cpuRdata;
      cpuReq = 1'b0;
    end
    if (!we) begin
      check(sawHit == expHit, expHit ? "R4 read hit same cycle" : "R5 read miss stalls",
            sawHit, expHit);
      check(got == expWord, expHit ? {"R4 read data ", lbl} : {"R5 read data ", lbl},
            got, expWord);
      check(memReads - rd0 == (expHit ? 0 : 1), "R5 block reads", memReads - rd0, expHit ? 0 : 1);
      if (!expHit)
        check(lastMemAddr == {addr[31:4], 4'b0}, "R5 aligned fetch address",
              lastMemAddr, {addr[31:4], 4'b0});
    end else begin
      expBlk = preBlk;
      expBlk[w*32 +: 32] = wd;
      check(memWrites - wr0 == 1, expHit ? "R6 one block write" : "R7 one block write",
            memWrites - wr0, 1);
      check(memReads - rd0 == (expHit ? 0 : 1), expHit ? "R6 no fetch on hit" : "R7 fetch on miss",
            memReads - rd0, expHit ? 0 : 1);
      check(refBlock(addr[31:4]) == expBlk, expHit ? "R6 written block" : "R7 merged block",
            refBlock(addr[31:4]), expBlk);
    end
  endtask

  // {we, addr, wdata, expHit}
  localparam logic [65:0] VECS [13] = '{
    {1'b0, 32'h0000_1230, 32'h0,          1'b0},  // cold miss
    {1'b0, 32'h0000_1234, 32'h0,          1'b1},  // same block hit
    {1'b1, 32'h0000_1238, 32'hDEAD_0001,  1'b1},  // write hit
    {1'b0, 32'h0000_1238, 32'h0,          1'b1},  // read back written word
    {1'b0, 32'h0005_1230, 32'h0,          1'b0},  // R2 same index other tag
    {1'b0, 32'h0000_123C, 32'h0,          1'b0},  // evicted, miss again
    {1'b1, 32'h0002_4564, 32'h0BEE_F002,  1'b0},  // write miss
    {1'b0, 32'h0002_4560, 32'h0,          1'b1},  // neighbour kept
    {1'b0, 32'h0002_4564, 32'h0,          1'b1},  // merged word
    {1'b0, 32'hFFFF_FFFC, 32'h0,          1'b0},  // top index and tag
    {1'b0, 32'hFFFF_FFF1, 32'h0,          1'b1},  // R1 byte offset ignored
    {1'b1, 32'h0000_0000, 32'h1111_0000,  1'b0},  // write miss index 0
    {1'b0, 32'h0000_000C, 32'h0,          1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int wr0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R3 reset state
    check(!cpuBusy && !memReq && !rspValid, "R3 outputs after reset",
          {cpuBusy, memReq, rspValid}, 3'b000);

    for (int i = 0; i < 13; i++) begin
      logic [65:0] v;
      string lbl;
      v   = VECS[i];
      lbl = (i == 4) ? "R2 conflict" : (i == 10) ? "R1 offset" : (i == 0) ? "R3 cold" : "";
      doAccess(v[65], v[64:33], v[32:1], v[0], 1'b0, lbl);
    end

    // R8: request held during a miss must be ignored
    wr0 = memWrites;
    doAccess(1'b0, 32'h0003_7770, 32'h0, 1'b0, 1'b1, "R8 busy");
    check(memWrites == wr0, "R8 ignored store while busy", memWrites - wr0, 0);
    doAccess(1'b0, 32'h0003_7670, 32'h0, 1'b0, 1'b0, "R8 untouched line");

    // R3: reset invalidates lines that were filled
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    doAccess(1'b0, 32'h0002_4564, 32'h0, 1'b0, 1'b0, "R3 after reset");
    doAccess(1'b0, 32'h0002_4568, 32'h0, 1'b1, 1'b0, "R3 refilled");

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule